// File: doc/BRIEF.md
# Analog Front-End Channel and Power Controller

This block sits behind the serial bus decoder of an eight-channel sampling converter. It accepts the meaningful bits of each command byte and turns them into registered controls for the analog front end: a one-hot select for the positive input and a one-hot select for the negative input. The negative select covers the eight channels plus a common return pin. It also produces an ADC-enable and a reference-enable. The channel field uses an interleaved mapping rather than a plain binary index. In differential mode the top channel bit swaps the polarity of a pair. In single-ended mode the same bit picks the odd member of the pair.

Reference power is sequenced against bus framing. A command that asks for the reference while it is off only arms a pending request. The reference comes on at the next STOP or repeated START pulse from the bus decoder. Each turn-on from off reloads a settling counter with the value on `settle_cycles`. The `ref_ready` flag goes high only when that count has run out, and it drops as soon as the reference goes off.

Commands arrive on a valid/ready handshake. `cmd_ready` is low while a conversion is busy. A command offered in that state is not taken: the source must hold it, or drop it, until ready returns. Holding it off keeps the selects steady during a conversion.

Top module: `chan_power_ctrl`

## Requirements
- R1: With cmd_word bit 5 (mode) at 0, the pair index is bits 3:2 and the polarity bit is bit 4. When bit 4 is 0, channel 2p drives pos_sel and channel 2p+1 drives neg_sel. When bit 4 is 1, the two are swapped, and neg_sel bit 8 stays 0.
- R2: With cmd_word bit 5 at 1, the positive channel index is {bit 3, bit 2, bit 4} and neg_sel is exactly bit 8 (common).
- R3: cmd_ready equals the inverse of conv_busy. pos_sel, neg_sel and the power state change only on the clock edge that follows a cycle with cmd_valid and cmd_ready both high. A command offered while busy has no effect.
- R4: adc_en stays high whenever the last accepted command had bit 0 set. Otherwise adc_en equals conv_busy.
- R5: After reset the selects are all zero, ref_en and ref_ready are low, and adc_en follows conv_busy.
- R6: An accepted command with bit 1 set while the reference is off leaves ref_en low. ref_en rises one edge after the next cycle with bus_stop or bus_rstart high. A bus event with nothing pending, or a bus event in the same cycle as an accepted command, has no effect.
- R7: An accepted command with bit 1 set while the reference is on keeps ref_en high and does not restart settling.
- R8: An accepted command with bit 1 clear drops ref_en and ref_ready on the next edge and cancels any pending turn-on.
- R9: ref_ready rises exactly settle_cycles+1 cycles after ref_en rises. The count starts again at every turn-on from off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_word | input | CH_AW+3 | Mode, channel code, reference request, ADC hold |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (not busy) |
| conv_busy | input | 1 | Conversion in progress |
| bus_stop | input | 1 | One-cycle STOP pulse from bus decoder |
| bus_rstart | input | 1 | One-cycle repeated START pulse |
| settle_cycles | input | SETTLE_W | Settling count loaded at reference turn-on |
| pos_sel | output | 2**CH_AW | One-hot positive input select |
| neg_sel | output | 2**CH_AW+1 | One-hot negative select, top bit is common |
| adc_en | output | 1 | Converter power enable |
| ref_en | output | 1 | Reference power enable |
| ref_ready | output | 1 | Reference settled |

## Verification
The bench builds the block with CH_AW=3 and SETTLE_W=4. This makes the command space only 64 words, so every code is swept for both select decodes and both ADC power modes, each with a busy-blocked command in between. The narrow counter lets settling be timed cycle by cycle at zero, small and full-scale counts, alternating STOP and repeated START as the trigger. Pending-cancel, keep-on and same-cycle collision cases are also checked.

// File: rtl/chan_power_pkg.sv
package chan_power_pkg;
  // Low bits of the command word, fixed for every channel width
  localparam int FLD_ADC_HOLD = 0;
  localparam int FLD_REF_REQ  = 1;
  localparam int FLD_CSEL_LO  = 2;

  typedef struct packed {
    logic ref_on;
    logic adc_hold;
  } pwr_req_t;

  function automatic pwr_req_t pwr_of(input logic [1:0] bits);
    pwr_req_t r;
    r.ref_on   = bits[FLD_REF_REQ];
    r.adc_hold = bits[FLD_ADC_HOLD];
    return r;
  endfunction
endpackage

// File: rtl/chan_sel_decode.sv
module chan_sel_decode #(
  parameter int CH_AW = 3,
  localparam int NCH  = 1 << CH_AW
) (
  input  logic             single_end,
  input  logic [CH_AW-1:0] csel,
  output logic [NCH-1:0]   pos_oh,
  output logic [NCH:0]     neg_oh
);
  logic [CH_AW-2:0] pair;
  logic             swap;
  logic [CH_AW-1:0] p_idx;
  logic [CH_AW-1:0] n_idx;

  assign pair  = csel[CH_AW-2:0];
  assign swap  = csel[CH_AW-1];
  // The positive index takes the same interleaved form in both modes
  assign p_idx = {pair, swap};
  assign n_idx = {pair, ~swap};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign pos_oh[i] = (p_idx == CH_AW'(i));
    assign neg_oh[i] = !single_end && (n_idx == CH_AW'(i));
  end
  assign neg_oh[NCH] = single_end;
endmodule

// File: rtl/ref_sequencer.sv
module ref_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_take,
  input  logic ref_req,
  input  logic bus_evt,
  output logic ref_on,
  output logic ref_on_nxt
);
  logic pend_q, pend_nxt;

  always_comb begin
    ref_on_nxt = ref_on;
    pend_nxt   = pend_q;
    if (cmd_take) begin
      if (!ref_req) begin
        ref_on_nxt = 1'b0;
        pend_nxt   = 1'b0;
      end else if (!ref_on) begin
        pend_nxt = 1'b1;
      end
    end else if (bus_evt && pend_q) begin
      ref_on_nxt = 1'b1;
      pend_nxt   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_on <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ref_on <= ref_on_nxt;
      pend_q <= pend_nxt;
    end
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_cur,
  input  logic                en_nxt,
  input  logic [SETTLE_W-1:0] load,
  output logic                ready
);
  logic [SETTLE_W-1:0] cnt_q;
  logic                start;

  assign start = en_nxt && !en_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (start) begin
      cnt_q <= load;
      ready <= 1'b0;
    end else if (!en_nxt) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      ready <= 1'b1;
    end
  end
endmodule

// File: rtl/chan_power_ctrl.sv
module chan_power_ctrl #(
  parameter int CH_AW    = 3,
  parameter int SETTLE_W = 16,
  localparam int NCH     = 1 << CH_AW,
  localparam int CW      = CH_AW + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       cmd_word,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                conv_busy,
  input  logic                bus_stop,
  input  logic                bus_rstart,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [NCH-1:0]      pos_sel,
  output logic [NCH:0]        neg_sel,
  output logic                adc_en,
  output logic                ref_en,
  output logic                ref_ready
);
  import chan_power_pkg::*;

  logic             take;
  pwr_req_t         req;
  logic [NCH-1:0]   pos_d;
  logic [NCH:0]     neg_d;
  logic             hold_q;
  logic             ref_nxt;

  assign cmd_ready = !conv_busy;
  assign take      = cmd_valid && cmd_ready;
  assign req       = pwr_of(cmd_word[1:0]);

  chan_sel_decode #(.CH_AW(CH_AW)) u_dec (
    .single_end (cmd_word[CW-1]),
    .csel       (cmd_word[FLD_CSEL_LO +: CH_AW]),
    .pos_oh     (pos_d),
    .neg_oh     (neg_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_sel <= '0;
      neg_sel <= '0;
      hold_q  <= 1'b0;
    end else if (take) begin
      pos_sel <= pos_d;
      neg_sel <= neg_d;
      hold_q  <= req.adc_hold;
    end
  end

  assign adc_en = hold_q || conv_busy;

  ref_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_take   (take),
    .ref_req    (req.ref_on),
    .bus_evt    (bus_stop || bus_rstart),
    .ref_on     (ref_en),
    .ref_on_nxt (ref_nxt)
  );

  settle_timer #(.SETTLE_W(SETTLE_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_cur (ref_en),
    .en_nxt (ref_nxt),
    .load   (settle_cycles),
    .ready  (ref_ready)
  );
endmodule

// File: rtl/chan_power_ctrl_chk.sv
module chan_power_ctrl_chk #(
  parameter int CH_AW = 3,
  localparam int NCH  = 1 << CH_AW,
  localparam int CW   = CH_AW + 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CW-1:0]  cmd_word,
  input logic           cmd_valid,
  input logic           conv_busy,
  input logic           bus_stop,
  input logic           bus_rstart,
  input logic [NCH-1:0] pos_sel,
  input logic [NCH:0]   neg_sel,
  input logic           ref_en,
  input logic           ref_ready
);
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |=> ($stable(pos_sel) && $stable(neg_sel)));

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pos_sel) && $onehot0(neg_sel) && ($countones(pos_sel) == $countones(neg_sel)));

  // R6
  ref_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> $past(bus_stop || bus_rstart));

  // R8
  ref_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !conv_busy && !cmd_word[1]) |=> (!ref_en && !ref_ready));

  // R9
  ready_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready |-> ref_en);

  // R9
  ready_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_ready) |-> $past(ref_en));
endmodule

bind chan_power_ctrl chan_power_ctrl_chk #(.CH_AW(CH_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_word   (cmd_word),
  .cmd_valid  (cmd_valid),
  .conv_busy  (conv_busy),
  .bus_stop   (bus_stop),
  .bus_rstart (bus_rstart),
  .pos_sel    (pos_sel),
  .neg_sel    (neg_sel),
  .ref_en     (ref_en),
  .ref_ready  (ref_ready)
);

// File: tb/chan_power_ctrl_test.sv
module chan_power_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CH_AW = 3;
  localparam int SW = 4;
  localparam int NCH = 1 << CH_AW;
  localparam int CW = CH_AW + 3;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cmd_word = '0;
  logic cmd_valid = 0, conv_busy = 0, bus_stop = 0, bus_rstart = 0;
  logic [SW-1:0] settle_cycles = '0;
  logic cmd_ready, adc_en, ref_en, ref_ready;
  logic [NCH-1:0] pos_sel;
  logic [NCH:0] neg_sel;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_power_ctrl #(.CH_AW(CH_AW), .SETTLE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .conv_busy(conv_busy), .bus_stop(bus_stop),
    .bus_rstart(bus_rstart), .settle_cycles(settle_cycles), .pos_sel(pos_sel),
    .neg_sel(neg_sel), .adc_en(adc_en), .ref_en(ref_en), .ref_ready(ref_ready));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [CW-1:0] w);
    @(negedge clk); cmd_word = w; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic evt(input bit rs);
    @(negedge clk); if (rs) bus_rstart = 1; else bus_stop = 1;
    @(negedge clk); bus_rstart = 0; bus_stop = 0;
  endtask

  function automatic logic [31:0] exp_pos(input logic [CW-1:0] w);
    int p = (w >> 2) & 3; int c2 = (w >> 4) & 1;
    return 32'd1 << (p * 2 + c2);
  endfunction

  function automatic logic [31:0] exp_neg(input logic [CW-1:0] w);
    int p = (w >> 2) & 3; int c2 = (w >> 4) & 1;
    if ((w >> 5) & 1) return 32'd1 << NCH;
    return 32'd1 << (p * 2 + 1 - c2);
  endfunction

  task automatic settle_run(input int s, input bit rs);
    send(6'h00);
    settle_cycles = SW'(s);
    send(6'h02);
    chk("R6 armed not on", ref_en, 0);
    @(negedge clk); chk("R6 still off", ref_en, 0);
    evt(rs);
    chk("R6 on after event", ref_en, 1);
    chk("R9 not ready at on", ref_ready, 0);
    for (int k = 1; k <= s; k++) begin
      @(negedge clk); chk("R9 settling", ref_ready, 0);
    end
    @(negedge clk); chk("R9 ready at count", ref_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5 reset state
    chk("R5 pos", pos_sel, 0); chk("R5 neg", neg_sel, 0);
    chk("R5 ref", ref_en, 0); chk("R5 rdy", ref_ready, 0);
    chk("R5 adc", adc_en, 0); chk("R5 ready", cmd_ready, 1);
    rst_n = 1;
    @(negedge clk);
    conv_busy = 1; #1 chk("R5 adc follows busy", adc_en, 1);
    chk("R3 ready low when busy", cmd_ready, 0);
    @(negedge clk); conv_busy = 0;

    // R1 R2 R3 R4 sweep of every command word
    for (int w = 0; w < 64; w++) begin
      send(CW'(w));
      if (w & 32) begin
        chk("R2 pos", pos_sel, exp_pos(CW'(w)));
        chk("R2 neg", neg_sel, exp_neg(CW'(w)));
      end else begin
        chk("R1 pos", pos_sel, exp_pos(CW'(w)));
        chk("R1 neg", neg_sel, exp_neg(CW'(w)));
      end
      chk("R4 idle adc", adc_en, w & 1);
      conv_busy = 1;
      send(CW'(w ^ 6'h3D));
      chk("R4 busy adc", adc_en, 1);
      chk("R3 busy pos kept", pos_sel, exp_pos(CW'(w)));
      chk("R3 busy neg kept", neg_sel, exp_neg(CW'(w)));
      conv_busy = 0;
      #1 chk("R3 busy hold mode", adc_en, w & 1);
    end

    // R9 settle timing with both trigger kinds
    settle_run(0, 0);
    settle_run(1, 1);
    settle_run(5, 0);
    settle_run(15, 1);

    // R7 keep-on without restart
    settle_cycles = 4'd9;
    send(6'h03);
    chk("R7 stays on", ref_en, 1);
    chk("R7 ready kept", ref_ready, 1);
    evt(0);
    chk("R7 evt no restart", ref_ready, 1);

    // R8 off and busy-blocked off request
    conv_busy = 1; send(6'h00); conv_busy = 0;
    chk("R3 blocked off cmd", ref_en, 1);
    send(6'h01);
    chk("R8 off", ref_en, 0); chk("R8 rdy off", ref_ready, 0);
    chk("R4 hold after off", adc_en, 1);

    // R8 cancel pending
    send(6'h02); send(6'h00); evt(0);
    chk("R8 cancelled pending", ref_en, 0);
    // R6 event without pending
    evt(1);
    chk("R6 idle event", ref_en, 0);

    // R6 collision: command and event same cycle
    send(6'h02);
    @(negedge clk); cmd_word = 6'h02; cmd_valid = 1; bus_stop = 1;
    @(negedge clk); cmd_valid = 0; bus_stop = 0;
    chk("R6 collision ignored", ref_en, 0);
    settle_cycles = 4'd2;
    evt(1);
    chk("R6 later event", ref_en, 1);
    repeat (3) @(negedge clk);
    chk("R9 restart settle", ref_ready, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule